// File: doc/BRIEF.md
# Eight-Stage Pipeline Interlock Unit

This block tracks the instructions in flight through an in-order, eight-stage integer pipeline and raises a stall for the instruction in the register-read stage whenever one of its source registers has not been produced in time. The stages, oldest last, are fetch (IF), decode (DE), register read (RR), two ALU stages (AL1, AL2), two data-memory stages (DM1, DM2) and register write (RW). Each stage takes one cycle. Every instruction carries a class (ALU, load or store), a destination register, two source registers and a use flag for each source. A load reads source A as its address. A store reads source A as its address and source B as its data, and it writes no register.

The unit holds the stage registers itself. A new instruction is accepted into IF in any cycle where `in_ready` is high. While a stall is active, IF, DE and RR keep their contents and an empty slot is pushed into AL1. The stages from AL1 to RW always advance. The `bypass_en` input selects the timing model. With bypassing off, results can be read only from the register file, so a consumer must reach RR in the cycle after its producer leaves RW. With bypassing on, an ALU result can be forwarded at the end of AL2 and a load result at the end of DM2. A consumer needs its operand at the start of AL1, except store data, which is needed at the start of DM1. The instruction in RW is presented on the write-back outputs.

Top module: `pipe_interlock`

## Requirements
- R1: After a synchronous reset, all stages are empty: `stall` is 0, `in_ready` is 1 and `wb_valid` is 0.
- R2: With `bypass_en`=0, a consumer that directly follows a producer of a register it reads stalls for exactly 5 cycles, whether the producer is an ALU instruction or a load.
- R3: With `bypass_en`=1, a consumer that directly follows an ALU producer stalls 1 cycle if the operand is needed at AL1, and 0 cycles if it is store data.
- R4: With `bypass_en`=1, an ALU instruction, load or store whose address (source A) comes from a directly preceding load stalls 3 cycles.
- R5: With `bypass_en`=1, a store whose data (source B) comes from a directly preceding load stalls 1 cycle.
- R6: Register 0, an operand whose use flag is 0, and an empty stage never cause a stall.
- R7: While `stall` is 1, `in_ready` is 0, IF/DE/RR hold and AL1 receives an empty slot. Instructions retire in order, none is lost or duplicated, and the gap between two retirements is the issue gap plus the stall cycles.
- R8: When k independent instructions separate producer and consumer, the stall is the directly-following stall minus k, with 0 as the lower bound.
- R9: A store writes no register, so no instruction stalls on a store's destination field.
- R10: An instruction accepted at a clock edge and never stalled appears on the write-back outputs 7 cycles after the edge that loads it into IF.
- R11: When several older instructions write a source register, the stall lasts until the latest-ready one is satisfied, which is the largest individual requirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass_en | input | 1 | 1 = forwarding timing, 0 = register-file-only timing |
| in_valid | input | 1 | Instruction offered to IF |
| in_cls | input | 2 | Class: 0 ALU, 1 load, 2 store |
| in_dst | input | REG_W | Destination register (ignored for stores) |
| in_src_a | input | REG_W | Source A (address for loads and stores) |
| in_src_b | input | REG_W | Source B (data for stores) |
| in_use_a | input | 1 | Source A is read |
| in_use_b | input | 1 | Source B is read |
| in_ready | output | 1 | IF accepts the offered instruction at the next edge |
| stall | output | 1 | RR instruction is held this cycle |
| wb_valid | output | 1 | RW stage holds an instruction |
| wb_cls | output | 2 | Class of the RW instruction |
| wb_dst | output | REG_W | Destination of the RW instruction |

## Verification
Inserting a bubble into AL1 and draining older instructions toward RW happen in the same cycle. The stall decision therefore depends on a producer that is itself moving during the stall. The sweep issues each producer/consumer pair with 0 to 3 fillers between them, in both bypass modes. It counts the stall cycles and the spacing between the two retirements, and judges both against a closed-form expected value. A three-instruction case, with two producers of the same register, checks that the longest requirement decides the stall when two hazards are open in the same cycle.

// File: rtl/pi_pkg.sv
package pi_pkg;
  parameter int unsigned REG_W = 5;
  localparam int unsigned NFRONT = 3;
  localparam int unsigned NBACK = 5;
  localparam int unsigned FIRST_BACK = NFRONT;

  typedef enum logic [1:0] {
    CLS_ALU   = 2'd0,
    CLS_LOAD  = 2'd1,
    CLS_STORE = 2'd2
  } cls_e;

  typedef struct packed {
    logic             v;
    cls_e             cls;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] sa;
    logic [REG_W-1:0] sb;
    logic             ua;
    logic             ub;
  } instr_t;

  // stage index at whose end the result can be used
  function automatic int ready_stage(cls_e c, logic bp);
    if (!bp) return 7;
    return (c == CLS_LOAD) ? 6 : 4;
  endfunction

  // stage index at whose start the operand is consumed
  function automatic int need_stage(cls_e c, logic is_b, logic bp);
    if (!bp) return 2;
    if (c == CLS_STORE && is_b) return 5;
    return 3;
  endfunction
endpackage

// File: rtl/pi_front.sv
module pi_front
  import pi_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   hold,
  input  instr_t in_i,
  output instr_t rr_o
);
  instr_t fq [NFRONT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NFRONT; i++) fq[i] <= '0;
    end else if (!hold) begin
      fq[0] <= in_i;
      for (int i = 1; i < NFRONT; i++) fq[i] <= fq[i-1];
    end
  end

  assign rr_o = fq[NFRONT-1];
endmodule

// File: rtl/pi_back.sv
module pi_back
  import pi_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bubble,
  input  instr_t               rr_i,
  output instr_t [NBACK-1:0]   bk_o
);
  instr_t [NBACK-1:0] bq;

  always_ff @(posedge clk) begin
    if (rst) begin
      bq <= '0;
    end else begin
      bq[0] <= bubble ? instr_t'('0) : rr_i;
      for (int i = 1; i < NBACK; i++) bq[i] <= bq[i-1];
    end
  end

  assign bk_o = bq;
endmodule

// File: rtl/pi_hazard.sv
module pi_hazard
  import pi_pkg::*;
(
  input  logic               bypass_en,
  input  instr_t             rr,
  input  instr_t [NBACK-1:0] bk,
  output logic               stall
);
  logic [NBACK-1:0] hit;

  always_comb begin
    for (int g = 0; g < NBACK; g++) begin
      logic writes;
      logic ma, mb;
      int   lim_a, lim_b;
      writes = bk[g].v && (bk[g].cls != CLS_STORE) && (bk[g].dst != '0);
      ma     = rr.ua && (rr.sa == bk[g].dst);
      mb     = rr.ub && (rr.sb == bk[g].dst);
      // producer at stage p blocks while p <= ready - need + RR index
      lim_a  = ready_stage(bk[g].cls, bypass_en)
             - need_stage(rr.cls, 1'b0, bypass_en) + (NFRONT - 1);
      lim_b  = ready_stage(bk[g].cls, bypass_en)
             - need_stage(rr.cls, 1'b1, bypass_en) + (NFRONT - 1);
      hit[g] = rr.v && writes &&
               ((ma && (int'(FIRST_BACK) + g <= lim_a)) ||
                (mb && (int'(FIRST_BACK) + g <= lim_b)));
    end
  end

  assign stall = |hit;
endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
  import pi_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bypass_en,
  input  logic             in_valid,
  input  logic [1:0]       in_cls,
  input  logic [REG_W-1:0] in_dst,
  input  logic [REG_W-1:0] in_src_a,
  input  logic [REG_W-1:0] in_src_b,
  input  logic             in_use_a,
  input  logic             in_use_b,
  output logic             in_ready,
  output logic             stall,
  output logic             wb_valid,
  output logic [1:0]       wb_cls,
  output logic [REG_W-1:0] wb_dst
);
  instr_t             in_w;
  instr_t             rr_q;
  instr_t [NBACK-1:0] bk_q;
  logic               hz;

  always_comb begin
    in_w     = '0;
    in_w.v   = in_valid;
    in_w.cls = cls_e'(in_cls);
    in_w.dst = in_dst;
    in_w.sa  = in_src_a;
    in_w.sb  = in_src_b;
    in_w.ua  = in_use_a;
    in_w.ub  = in_use_b;
  end

  pi_front u_front (
    .clk  (clk),
    .rst  (rst),
    .hold (hz),
    .in_i (in_w),
    .rr_o (rr_q)
  );

  pi_back u_back (
    .clk    (clk),
    .rst    (rst),
    .bubble (hz),
    .rr_i   (rr_q),
    .bk_o   (bk_q)
  );

  pi_hazard u_hz (
    .bypass_en (bypass_en),
    .rr        (rr_q),
    .bk        (bk_q),
    .stall     (hz)
  );

  assign stall    = hz;
  assign in_ready = !hz;
  assign wb_valid = bk_q[NBACK-1].v;
  assign wb_cls   = bk_q[NBACK-1].cls;
  assign wb_dst   = bk_q[NBACK-1].dst;
endmodule

// File: rtl/pi_checker.sv
module pi_checker
  import pi_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   bypass_en,
  input logic   stall,
  input logic   wb_valid,
  input instr_t rr_q,
  input instr_t al1_q
);
  logic [3:0] run;

  always_ff @(posedge clk) begin
    if (rst) run <= '0;
    else if (stall) run <= (run == 4'hF) ? run : run + 4'd1;
    else run <= '0;
  end

  // R1
  reset_empty_chk: assert property (@(posedge clk) rst |=> (!wb_valid && !stall));

  // R7
  bubble_chk: assert property (@(posedge clk) disable iff (rst) stall |=> !al1_q.v);

  // R7
  rr_hold_chk: assert property (@(posedge clk) disable iff (rst) stall |=> (rr_q == $past(rr_q)));

  // R6
  empty_rr_chk: assert property (@(posedge clk) disable iff (rst) stall |-> rr_q.v);

  // R2
  run_nobyp_chk: assert property (@(posedge clk) disable iff (rst) run <= 4'd5);

  // R4
  run_byp_chk: assert property (@(posedge clk) disable iff (rst) bypass_en |-> run <= 4'd3);
endmodule

bind pipe_interlock pi_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .bypass_en (bypass_en),
  .stall     (stall),
  .wb_valid  (wb_valid),
  .rr_q      (rr_q),
  .al1_q     (bk_q[0])
);

// File: tb/sim_pipe_interlock.sv
`timescale 1ns/1ps
module sim_pipe_interlock;
  localparam int RW = pi_pkg::REG_W;

  logic          clk = 0;
  logic          rst = 1;
  logic          bypass_en = 0;
  logic          in_valid = 0;
  logic [1:0]    in_cls = 0;
  logic [RW-1:0] in_dst = 0, in_src_a = 0, in_src_b = 0;
  logic          in_use_a = 0, in_use_b = 0;
  logic          in_ready, stall, wb_valid;
  logic [1:0]    wb_cls;
  logic [RW-1:0] wb_dst;

  int errors = 0, checks = 0;
  int cyc = 0, stall_cnt = 0, ret_n = 0;
  int ret_t [16];
  bit done = 0;

  always #4 clk = ~clk;

  pipe_interlock u0 (
    .clk(clk), .rst(rst), .bypass_en(bypass_en), .in_valid(in_valid),
    .in_cls(in_cls), .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_use_a(in_use_a), .in_use_b(in_use_b), .in_ready(in_ready),
    .stall(stall), .wb_valid(wb_valid), .wb_cls(wb_cls), .wb_dst(wb_dst)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (stall) stall_cnt++;
      if (wb_valid && ret_n < 16) begin
        ret_t[ret_n] = cyc;
        ret_n++;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // returns the cycle count at the negedge after the accepting edge
  task automatic send(input int cls, input int dst, input int sa, input int sb,
                      input bit ua, input bit ub, output int t_acc);
    in_valid = 1; in_cls = cls[1:0]; in_dst = dst[RW-1:0];
    in_src_a = sa[RW-1:0]; in_src_b = sb[RW-1:0]; in_use_a = ua; in_use_b = ub;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    t_acc = cyc;
    in_valid = 0; in_use_a = 0; in_use_b = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int expect_stall(bit bp, int pcls, int ccase, int gap);
    int r, n, s;
    if (pcls == 2) return 0;
    r = !bp ? 7 : (pcls == 1 ? 6 : 4);
    n = !bp ? 2 : (ccase == 3 ? 5 : 3);
    s = r - n - gap;
    return (s > 0) ? s : 0;
  endfunction

  initial begin
    int t;
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 stall", int'(stall), 0);
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 wb_valid", int'(wb_valid), 0);

    // R10 latency of a lone instruction
    ret_n = 0;
    send(0, 7, 0, 0, 0, 0, t);
    idle(12);
    chk("R10 latency", ret_t[0] - t, 7);
    chk("R10 wb_dst", ret_n, 1);

    // pair sweep: both modes x producer class x consumer kind x gap
    for (int bp = 0; bp < 2; bp++) begin
      bypass_en = bp[0];
      for (int pc = 0; pc < 3; pc++) begin
        for (int cc = 0; cc < 5; cc++) begin
          for (int gap = 0; gap < 4; gap++) begin
            int exp_s, ccls, tp;
            string tag;
            exp_s = expect_stall(bp[0], pc, cc, gap);
            ccls = (cc < 2) ? 0 : (cc < 4 ? 2 : 1);
            if (pc == 2) tag = "R9";
            else if (gap > 0) tag = "R8";
            else if (bp == 0) tag = "R2";
            else if (pc == 0) tag = "R3";
            else if (cc == 3) tag = "R5";
            else tag = "R4";
            stall_cnt = 0; ret_n = 0;
            send(pc, 5, 1, 2, pc != 2 ? 1'b1 : 1'b1, pc == 2, tp);
            for (int k = 0; k < gap; k++) send(0, 20 + k, 0, 0, 0, 0, t);
            send(ccls, 9, (cc == 1 || cc == 3) ? 3 : 5, (cc == 1 || cc == 3) ? 5 : 3,
                 !(cc == 1 || cc == 3), (cc == 1 || cc == 3), t);
            idle(16);
            chk(tag, stall_cnt, exp_s);
            chk("R7 retire gap", ret_t[ret_n-1] - ret_t[0], gap + 1 + exp_s);
            chk("R7 retire count", ret_n, gap + 2);
          end
        end
      end
    end

    // R6 register 0 and unused operand, both modes
    for (int bp = 0; bp < 2; bp++) begin
      bypass_en = bp[0];
      stall_cnt = 0;
      send(1, 0, 1, 0, 1, 0, t);
      send(0, 9, 0, 0, 1, 1, t);
      idle(14);
      chk("R6 reg0", stall_cnt, 0);
      stall_cnt = 0;
      send(1, 5, 1, 0, 1, 0, t);
      send(0, 9, 5, 5, 0, 0, t);
      idle(14);
      chk("R6 unused operand", stall_cnt, 0);
    end

    // R11 two producers of the same register: load then ALU, bypass on
    bypass_en = 1;
    stall_cnt = 0; ret_n = 0;
    send(1, 6, 1, 0, 1, 0, t);
    send(0, 6, 2, 0, 1, 0, t);
    send(0, 9, 6, 0, 1, 0, t);
    idle(16);
    // ALU producer alone would need 1; load one gap back needs 3-1 = 2
    chk("R11 max of hazards", stall_cnt, 2);
    chk("R11 retire count", ret_n, 3);

    done = 1;
    summary();
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
    end
  end
endmodule